// File: doc/BRIEF.md
# Comparator Reference DAC Mode Sequencer

This block produces the 10-bit code that feeds a comparator's reference DAC. Software programs it through a small register write/read port. It picks one of four code-generation modes, loads the values that mode uses, and starts the mode. A start can come from software directly, or software can arm the block so that a chosen hardware trigger line begins the mode. After that, a chosen update source paces each change to the code. That source is one of the hardware trigger lines, a local reload counter, or the comparator result taken either as is or inverted.

The four modes work as follows. Direct mode leaves the code alone and only reports completion. Buffered mode copies a staged value to the output and signals that the stage is empty. Hysteretic mode flips between two programmed levels on comparator edges. Ramp mode steps by a signed increment toward an end value. A direct write of the code always wins: it replaces the output and aborts whatever mode is running. Completion, buffer-empty and hardware-start are reported as one-cycle event pulses.

The reset input is asynchronous and active low, and the block releases it internally on the clock through two flops.

Top module: `refdac_seq`

## Requirements
- R1: While reset is held and right after it, the code is 0, the busy flag (bit 2 of START) is 0, both start bits are 0 and all three events are low.
- R2: A write to VALUE (address 2) puts wr_data[9:0] on the code at the next edge. It clears busy and both start bits, and it takes priority over an update trigger in the same cycle.
- R3: Writing START (address 1) with bit 0 set while idle sets busy at the next edge. In hysteretic mode (CTRL[1:0]=2) and ramp mode (3), that same edge loads VAL_A (address 3) onto the code.
- R4: Writing START with only bit 1 set arms the block without making it busy. Busy rises, and evt_hw_start pulses, one edge after the trigger line chosen by CTRL[7:4] is sampled high. VAL_A is loaded as in R3. A start trigger while busy raises no event and leaves the code unchanged.
- R5: Writing START with both bits 0 stops a running mode. Busy falls and the code keeps its last value, even when later update triggers arrive.
- R6: Writes to CTRL (address 0) are ignored while busy, so the mode, continuous bit and trigger selections cannot change during a run.
- R7: In buffered mode (1), each update copies VAL_A to the code and pulses evt_buf_empty for one cycle.
- R8: In hysteretic mode, each rising edge of the comparator source sets the code to VAL_B (address 4) if the code equals VAL_A, and to VAL_A otherwise. Update select NTRIG+1 uses cmp_in and NTRIG+2 uses its inverse. These two selections cause no update in any other mode.
- R9: In ramp mode, each update adds the signed STEP (address 5, 10-bit two's complement) to the code. When the sum reaches or passes VAL_B in the direction of the step, the code becomes VAL_B and evt_slope_done pulses. Busy and the start bits then clear unless CTRL[2] (continuous) is set. In continuous mode, the next update after the end reloads VAL_A.
- R10: Update select NTRIG uses the local counter, which gives one update every PERIOD+1 cycles (PERIOD at address 6) while busy.
- R11: In direct mode (0), an update pulses evt_slope_done and leaves the code unchanged. Busy then clears unless continuous is set.
- R12: Update selects 0..NTRIG-1 pick trig_in bits. The read port returns the code at address 2 and {busy, hw start bit, fw start bit} in bits 2..0 at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| trig_in | input | NTRIG | Hardware trigger lines |
| cmp_in | input | 1 | Comparator result, synchronous |
| dac_code | output | 10 | Code to the reference DAC |
| evt_buf_empty | output | 1 | Buffered value consumed |
| evt_hw_start | output | 1 | Mode started by hardware trigger |
| evt_slope_done | output | 1 | Mode completed |

## Verification
Two functions can land in the same cycle. The first pair is a direct VALUE write and an update trigger. The bench drives both in one vector while a ramp is running, and it expects the written code with busy low rather than the stepped value. The second pair is a start-trigger assertion and an active run. The bench repeats the start trigger one cycle after a hardware start, and it judges the result by the absence of a second start event and by an unchanged code.

// File: rtl/refdac_pkg.sv
`timescale 1ns/1ps
package refdac_pkg;
  typedef enum logic [1:0] {
    M_DIRECT = 2'd0,
    M_BUFFER = 2'd1,
    M_HYST   = 2'd2,
    M_RAMP   = 2'd3
  } mode_e;

  localparam int          DATA_W       = 16;
  localparam int          ADDR_W       = 3;
  localparam int          SEL_W        = 4;
  localparam int          CTL_CONT_BIT = 2;
  localparam int          CTL_SSEL_LSB = 4;
  localparam int          CTL_USEL_LSB = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_START  = 3'd1;
  localparam logic [ADDR_W-1:0] A_VALUE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_VALA   = 3'd3;
  localparam logic [ADDR_W-1:0] A_VALB   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STEP   = 3'd5;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd6;
endpackage

// File: rtl/refdac_period.sv
`timescale 1ns/1ps
module refdac_period #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = period;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: a reload of a nonzero period never produces back-to-back ticks
  p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period != '0) |=> !tick);
endmodule

// File: rtl/refdac_trig.sv
`timescale 1ns/1ps
module refdac_trig
  import refdac_pkg::*;
#(
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             cmp_in,
  input  logic             hyst_mode,
  input  logic [SEL_W-1:0] start_sel,
  input  logic [SEL_W-1:0] upd_sel,
  input  logic             period_tick,
  output logic             start_hit,
  output logic             upd_hit
);
  localparam logic [SEL_W-1:0] SEL_PER  = SEL_W'(NTRIG);
  localparam logic [SEL_W-1:0] SEL_CMP  = SEL_W'(NTRIG + 1);
  localparam logic [SEL_W-1:0] SEL_CMPN = SEL_W'(NTRIG + 2);

  logic cmp_q;
  logic inv, cur_lvl, prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_in;
  end

  assign inv      = (upd_sel == SEL_CMPN);
  assign cur_lvl  = cmp_in ^ inv;
  assign prev_lvl = cmp_q ^ inv;

  always_comb begin
    start_hit = 1'b0;
    upd_hit   = 1'b0;
    for (int i = 0; i < NTRIG; i++) begin
      if (start_sel == SEL_W'(i)) start_hit = trig_in[i];
      if (upd_sel   == SEL_W'(i)) upd_hit   = trig_in[i];
    end
    if (upd_sel == SEL_PER) upd_hit = period_tick;
    if ((upd_sel == SEL_CMP) || (upd_sel == SEL_CMPN))
      upd_hit = hyst_mode && cur_lvl && !prev_lvl;
  end

  // R8: comparator-paced updates exist only in hysteretic mode
  p_cmp_only_hyst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hyst_mode && (upd_sel == SEL_CMP || upd_sel == SEL_CMPN)) |-> !upd_hit);
endmodule

// File: rtl/refdac_engine.sv
`timescale 1ns/1ps
module refdac_engine
  import refdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              cont,
  input  logic [CODE_W-1:0] val_a,
  input  logic [CODE_W-1:0] val_b,
  input  logic [CODE_W-1:0] step,
  input  logic              wr_start,
  input  logic [1:0]        start_d,
  input  logic              wr_value,
  input  logic [CODE_W-1:0] value_d,
  input  logic              start_hit,
  input  logic              upd_hit,
  output logic [CODE_W-1:0] code_q,
  output logic              busy_q,
  output logic              fw_q,
  output logic              hw_q,
  output logic              ev_buf_q,
  output logic              ev_hw_q,
  output logic              ev_done_q
);
  localparam int SW = CODE_W + 2;

  logic [CODE_W-1:0] code_d;
  logic busy_d, fw_d, hw_d, ev_buf_d, ev_hw_d, ev_done_d;
  logic load_a, finish;
  logic signed [SW-1:0] ramp_sum, end_s;
  logic reached;

  assign end_s    = $signed({2'b00, val_b});
  assign ramp_sum = $signed({2'b00, code_q}) + $signed({{2{step[CODE_W-1]}}, step});
  assign reached  = step[CODE_W-1] ? (ramp_sum <= end_s) : (ramp_sum >= end_s);

  always_comb begin
    code_d = code_q;  busy_d = busy_q;  fw_d = fw_q;  hw_d = hw_q;
    ev_buf_d = 1'b0;  ev_hw_d = 1'b0;   ev_done_d = 1'b0;
    load_a = 1'b0;    finish = 1'b0;
    if (wr_value) begin
      code_d = value_d;
      busy_d = 1'b0; fw_d = 1'b0; hw_d = 1'b0;
    end else if (wr_start) begin
      fw_d   = start_d[0];
      hw_d   = start_d[1];
      busy_d = busy_q && ((fw_q && start_d[0]) || (hw_q && start_d[1]));
      if (start_d[0] && !busy_q) begin
        busy_d = 1'b1;
        load_a = 1'b1;
      end
    end else if (busy_q && upd_hit) begin
      unique case (mode)
        M_DIRECT: finish = 1'b1;
        M_BUFFER: begin code_d = val_a; ev_buf_d = 1'b1; end
        M_HYST:   code_d = (code_q == val_a) ? val_b : val_a;
        M_RAMP: begin
          if (cont && code_q == val_b) code_d = val_a;
          else if (reached) begin code_d = val_b; finish = 1'b1; end
          else code_d = ramp_sum[CODE_W-1:0];
        end
        default: ;
      endcase
      if (finish) begin
        ev_done_d = 1'b1;
        if (!cont) begin busy_d = 1'b0; fw_d = 1'b0; hw_d = 1'b0; end
      end
    end else if (hw_q && !busy_q && start_hit) begin
      busy_d  = 1'b1;
      ev_hw_d = 1'b1;
      load_a  = 1'b1;
    end
    if (load_a && (mode == M_HYST || mode == M_RAMP)) code_d = val_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0; busy_q <= 1'b0; fw_q <= 1'b0; hw_q <= 1'b0;
      ev_buf_q <= 1'b0; ev_hw_q <= 1'b0; ev_done_q <= 1'b0;
    end else begin
      code_q <= code_d; busy_q <= busy_d; fw_q <= fw_d; hw_q <= hw_d;
      ev_buf_q <= ev_buf_d; ev_hw_q <= ev_hw_d; ev_done_q <= ev_done_d;
    end
  end

  // R4: a hardware start event only marks an idle-to-busy transition
  p_hw_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hw_q |-> (busy_q && !$past(busy_q)));
  // R9: completion without continuous mode releases the run
  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_q && !cont) |-> (!busy_q && !fw_q && !hw_q));
  // R7: buffer-empty means the staged value reached the output
  p_buf_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_q |-> (busy_q && code_q == $past(val_a)));
endmodule

// File: rtl/refdac_seq.sv
`timescale 1ns/1ps
module refdac_seq
  import refdac_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int NTRIG  = 4,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [15:0]       rd_data,
  input  logic [NTRIG-1:0]  trig_in,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              evt_buf_empty,
  output logic              evt_hw_start,
  output logic              evt_slope_done
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  mode_e             mode_q;
  logic              cont_q;
  logic [SEL_W-1:0]  ssel_q, usel_q;
  logic [CODE_W-1:0] vala_q, valb_q, step_q;
  logic [PER_W-1:0]  per_q;
  logic              busy, fw, hw, tick, start_hit, upd_hit;
  logic              we_ctrl, we_vala, we_valb, we_step, we_per, we_start, we_value;

  assign we_ctrl  = wr_en && wr_addr == A_CTRL && !busy;
  assign we_start = wr_en && wr_addr == A_START;
  assign we_value = wr_en && wr_addr == A_VALUE;
  assign we_vala  = wr_en && wr_addr == A_VALA;
  assign we_valb  = wr_en && wr_addr == A_VALB;
  assign we_step  = wr_en && wr_addr == A_STEP;
  assign we_per   = wr_en && wr_addr == A_PERIOD;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= M_DIRECT; cont_q <= 1'b0; ssel_q <= '0; usel_q <= '0;
      vala_q <= '0; valb_q <= '0; step_q <= '0; per_q <= '0;
    end else begin
      if (we_ctrl) begin
        mode_q <= mode_e'(wr_data[1:0]);
        cont_q <= wr_data[CTL_CONT_BIT];
        ssel_q <= wr_data[CTL_SSEL_LSB +: SEL_W];
        usel_q <= wr_data[CTL_USEL_LSB +: SEL_W];
      end
      if (we_vala) vala_q <= wr_data[CODE_W-1:0];
      if (we_valb) valb_q <= wr_data[CODE_W-1:0];
      if (we_step) step_q <= wr_data[CODE_W-1:0];
      if (we_per)  per_q  <= wr_data[PER_W-1:0];
    end
  end

  refdac_period #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst_n(rst_s_n), .run(busy), .period(per_q), .tick(tick)
  );

  refdac_trig #(.NTRIG(NTRIG)) u_trig (
    .clk(clk), .rst_n(rst_s_n), .trig_in(trig_in), .cmp_in(cmp_in),
    .hyst_mode(mode_q == M_HYST), .start_sel(ssel_q), .upd_sel(usel_q),
    .period_tick(tick), .start_hit(start_hit), .upd_hit(upd_hit)
  );

  refdac_engine #(.CODE_W(CODE_W)) u_engine (
    .clk(clk), .rst_n(rst_s_n), .mode(mode_q), .cont(cont_q),
    .val_a(vala_q), .val_b(valb_q), .step(step_q),
    .wr_start(we_start), .start_d(wr_data[1:0]),
    .wr_value(we_value), .value_d(wr_data[CODE_W-1:0]),
    .start_hit(start_hit), .upd_hit(upd_hit),
    .code_q(dac_code), .busy_q(busy), .fw_q(fw), .hw_q(hw),
    .ev_buf_q(evt_buf_empty), .ev_hw_q(evt_hw_start), .ev_done_q(evt_slope_done)
  );

  always_comb begin
    unique case (rd_addr)
      A_CTRL:   rd_data = DATA_W'({usel_q, ssel_q, 1'b0, cont_q, mode_q});
      A_START:  rd_data = DATA_W'({busy, hw, fw});
      A_VALUE:  rd_data = DATA_W'(dac_code);
      A_VALA:   rd_data = DATA_W'(vala_q);
      A_VALB:   rd_data = DATA_W'(valb_q);
      A_STEP:   rd_data = DATA_W'(step_q);
      A_PERIOD: rd_data = DATA_W'(per_q);
      default:  rd_data = '0;
    endcase
  end

  // R2: a value write lands on the output and cancels the run
  p_value_abort_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && wr_addr == A_VALUE) |=> (!busy && dac_code == $past(wr_data[CODE_W-1:0])));
  // R6: the mode cannot move while a run continues
  p_mode_frozen_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(cont_q)));
endmodule

// File: tb/refdac_seq_bench.sv
`timescale 1ns/1ps
module refdac_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [3:0]  trig_in;
  logic        cmp_in;
  logic [9:0]  dac_code;
  logic        evt_buf_empty, evt_hw_start, evt_slope_done;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  refdac_seq u_refdac_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_in(trig_in), .cmp_in(cmp_in),
    .dac_code(dac_code), .evt_buf_empty(evt_buf_empty),
    .evt_hw_start(evt_hw_start), .evt_slope_done(evt_slope_done)
  );

  // {req, wen, addr, data, trig, cmp, exp_code, exp_busy, exp_ev(buf,hw,done)}
  function automatic logic [42:0] mk(input logic [3:0] rq, input logic w,
      input logic [2:0] a, input logic [15:0] d, input logic [3:0] t, input logic c,
      input logic [9:0] cd, input logic b, input logic [2:0] ev);
    return {rq, w, a, d, t, c, cd, b, ev};
  endfunction

  localparam int NV = 49;
  localparam logic [42:0] VEC [NV] = '{
    mk(2, 1,2,16'h0155,0,0,10'h155,0,3'b000), // R2 value write
    mk(2, 1,3,16'h0020,0,0,10'h155,0,3'b000), // A=32
    mk(2, 1,4,16'h0040,0,0,10'h155,0,3'b000), // B=64
    mk(2, 1,5,16'h0010,0,0,10'h155,0,3'b000), // step=16
    mk(6, 1,0,16'h0013,0,0,10'h155,0,3'b000), // R6 ramp, start sel 1, upd sel 0
    mk(3, 1,1,16'h0001,0,0,10'h020,1,3'b000), // R3 fw start loads A
    mk(9, 0,0,16'h0000,1,0,10'h030,1,3'b000), // R9 step
    mk(9, 0,0,16'h0000,1,0,10'h040,0,3'b001), // R9 end reached, done
    mk(9, 0,0,16'h0000,1,0,10'h040,0,3'b000), // R9 idle: no change
    mk(4, 1,1,16'h0002,0,0,10'h040,0,3'b000), // R4 arm
    mk(4, 0,0,16'h0000,1,0,10'h040,0,3'b000), // R4 other line does not start
    mk(4, 0,0,16'h0000,2,0,10'h020,1,3'b010), // R4 start trigger
    mk(4, 0,0,16'h0000,2,0,10'h020,1,3'b000), // R4 retrigger ignored
    mk(6, 1,0,16'h0010,0,0,10'h020,1,3'b000), // R6 ctrl write while busy
    mk(6, 0,0,16'h0000,1,0,10'h030,1,3'b000), // R6 still ramping
    mk(2, 1,2,16'h03FF,1,0,10'h3FF,0,3'b000), // R2 write beats update
    mk(2, 0,0,16'h0000,1,0,10'h3FF,0,3'b000), // R2 aborted
    mk(9, 1,5,16'h03F0,0,0,10'h3FF,0,3'b000), // step=-16
    mk(9, 1,3,16'h0040,0,0,10'h3FF,0,3'b000),
    mk(9, 1,4,16'h0020,0,0,10'h3FF,0,3'b000),
    mk(9, 1,0,16'h0017,0,0,10'h3FF,0,3'b000), // ramp continuous
    mk(3, 1,1,16'h0001,0,0,10'h040,1,3'b000), // R3
    mk(9, 0,0,16'h0000,1,0,10'h030,1,3'b000),
    mk(9, 0,0,16'h0000,1,0,10'h020,1,3'b001), // R9 done, stays busy
    mk(9, 0,0,16'h0000,1,0,10'h040,1,3'b000), // R9 reload A
    mk(5, 1,1,16'h0000,0,0,10'h040,0,3'b000), // R5 stop
    mk(5, 0,0,16'h0000,1,0,10'h040,0,3'b000), // R5 held
    mk(8, 1,0,16'h0602,0,1,10'h040,0,3'b000), // hyst, inverted comparator
    mk(3, 1,1,16'h0001,0,1,10'h040,1,3'b000), // R3 loads A
    mk(8, 0,0,16'h0000,0,0,10'h020,1,3'b000), // R8 flip to B
    mk(8, 0,0,16'h0000,0,0,10'h020,1,3'b000),
    mk(8, 0,0,16'h0000,0,1,10'h020,1,3'b000),
    mk(8, 0,0,16'h0000,0,0,10'h040,1,3'b000), // R8 back to A
    mk(8, 0,0,16'h0000,1,0,10'h040,1,3'b000), // R8 trig line unused
    mk(5, 1,1,16'h0000,0,0,10'h040,0,3'b000),
    mk(8, 1,0,16'h0501,0,0,10'h040,0,3'b000), // buffered, comparator src
    mk(7, 1,3,16'h00AA,0,0,10'h040,0,3'b000),
    mk(7, 1,1,16'h0001,0,0,10'h040,1,3'b000),
    mk(8, 0,0,16'h0000,0,1,10'h040,1,3'b000), // R8 ignored outside hyst
    mk(5, 1,1,16'h0000,0,1,10'h040,0,3'b000),
    mk(7, 1,0,16'h0001,0,0,10'h040,0,3'b000),
    mk(7, 1,1,16'h0001,0,0,10'h040,1,3'b000),
    mk(7, 0,0,16'h0000,1,0,10'h0AA,1,3'b100), // R7 copy + empty
    mk(7, 1,3,16'h00BB,0,0,10'h0AA,1,3'b000),
    mk(7, 0,0,16'h0000,1,0,10'h0BB,1,3'b100), // R7
    mk(5, 1,1,16'h0000,0,0,10'h0BB,0,3'b000),
    mk(11,1,0,16'h0000,0,0,10'h0BB,0,3'b000), // direct mode
    mk(11,1,1,16'h0001,0,0,10'h0BB,1,3'b000),
    mk(11,0,0,16'h0000,1,0,10'h0BB,0,3'b001)  // R11 done, code kept
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = 3'd1; trig_in = '0; cmp_in = 1'b0;
    repeat (3) cyc();
    // R1 reset state
    chk(dac_code == 10'd0, "R1 code in reset", dac_code, 0);
    chk(rd_data[2:0] == 3'b000, "R1 start/busy in reset", rd_data[2:0], 0);
    chk({evt_buf_empty, evt_hw_start, evt_slope_done} == 3'b000, "R1 events",
        {evt_buf_empty, evt_hw_start, evt_slope_done}, 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk(dac_code == 10'd0 && rd_data[2:0] == 3'b000, "R1 after release",
        {rd_data[2:0], dac_code}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      wr_en = v[38]; wr_addr = v[37:35]; wr_data = v[34:19];
      trig_in = v[18:15]; cmp_in = v[14];
      cyc();
      n_chk++;
      if (dac_code != v[13:4] || rd_data[2] != v[3] ||
          {evt_buf_empty, evt_hw_start, evt_slope_done} != v[2:0]) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: code=%h busy=%b ev=%b expected code=%h busy=%b ev=%b",
                 v[42:39], i, dac_code, rd_data[2],
                 {evt_buf_empty, evt_hw_start, evt_slope_done}, v[13:4], v[3], v[2:0]);
      end
    end
    wr_en = 1'b0; trig_in = '0; cmp_in = 1'b0;

    // R10 period counter pacing a ramp: one step every PERIOD+1 cycles
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h03FF);
    wr(3'd5, 16'h0001);
    wr(3'd6, 16'h0003);
    wr(3'd0, 16'h0403);
    wr(3'd1, 16'h0001);
    for (int k = 1; k <= 8; k++) begin
      cyc();
      chk(dac_code == 10'(k / 4), "R10 period pacing", dac_code, k / 4);
    end

    // R12 read port
    rd_addr = 3'd2; #0.1;
    chk(rd_data == 16'd2, "R12 read code", rd_data, 2);
    rd_addr = 3'd1; #0.1;
    chk(rd_data == 16'h0005, "R12 read start/busy", rd_data, 5);

    // R1 reset during a run
    rst_n = 1'b0;
    cyc();
    chk(dac_code == 10'd0 && rd_data == 16'h0000, "R1 reset mid-run",
        {rd_data[2:0], dac_code}, 0);
    rst_n = 1'b1;
    repeat (3) cyc();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule